// File: doc/BRIEF.md
# DDR2 Bank Timing Guard

This block sits beside a DDR2 command scheduler and keeps a small record of every bank's row state. For each of the eight banks it reports, on every clock, whether an activate, a column access (read or write) or a precharge may go out now. Three minimum delays are tracked at once in each bank: activate to column access, precharge to activate, and activate to activate. The scheduler presents each command it issues on a one-cycle strobe with the command kind and bank number. If a command breaks a rule, the guard flags it and ignores it.

The cycle counts come from nanosecond minimums (15 ns, 15 ns and 55 ns), divided by the clock period of the selected speed grade and rounded up. There are two grades: a 5.0 ns clock and a 3.75 ns clock. A refresh timer runs alongside the banks. It raises a request that stays set once the refresh interval has elapsed. In the high-temperature setting the interval is half as long. The scheduler clears the request with an acknowledge pulse.

Top module: `ddr_bank_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every bit of `act_ok` is 1, every bit of `col_ok` and `pre_ok` is 0, and `viol` and `ref_req` are 0.
- R2: `cmd_kind` uses this encoding: 0 = no operation, 1 = activate, 2 = column access, 3 = precharge. A no-operation command is ignored. A command changes only the bank that `cmd_bank` selects.
- R3: The timing values come from `grade_fast`. When it is 0, tRCD = tRP = 3 cycles and tRC = 11 cycles. When it is 1, tRCD = tRP = 4 cycles and tRC = 15 cycles.
- R4: After an activate accepted at clock edge T, that bank's `col_ok` is 0 until edge T+tRCD, and 1 from then on while the row stays open.
- R5: A bank's `act_ok` is 1 only when three things hold: the bank is closed, at least tRP edges have passed since its last accepted precharge, and at least tRC edges have passed since its last accepted activate.
- R6: `pre_ok` is 1 exactly while the bank is open. An accepted precharge closes the bank, which drops `col_ok` and `pre_ok` on the next cycle.
- R7: A command sent to a bank whose matching ready flag is 0 raises `viol` for exactly the cycle after it is issued, and leaves that bank's flags and timers unchanged.
- R8: `ref_req` rises N clock edges after reset is released, where N = ceil(REF_NS / clock period of the grade). When `hot_mode` = 1, N is halved and rounded down. After each interval the timer restarts.
- R9: `ref_req` stays set until `ref_ack` is sampled high, and clears on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_kind | input | 2 | Command kind: 0 none, 1 activate, 2 column access, 3 precharge |
| cmd_bank | input | 3 | Target bank number |
| grade_fast | input | 1 | 0 selects 5.0 ns timing, 1 selects 3.75 ns timing |
| hot_mode | input | 1 | Halves the refresh interval |
| ref_ack | input | 1 | Clears the refresh request |
| act_ok | output | 8 | Per-bank activate allowed |
| col_ok | output | 8 | Per-bank read/write allowed |
| pre_ok | output | 8 | Per-bank precharge allowed |
| viol | output | 1 | Illegal command seen on the previous cycle |
| ref_req | output | 1 | Sticky refresh request |

## Verification
The bench uses the default eight banks and sets REF_NS to 160. That gives refresh intervals of 32 and 43 cycles, and 16 and 21 cycles in hot mode, so every refresh boundary and the sticky hold can be reached in a few dozen cycles instead of thousands. The bank timing does not depend on parameters. Both grades are driven at run time, so the 3/11 and 4/15 cycle edges of the column-access and activate windows are each checked one cycle before and on the boundary.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    // nanosecond minimums and clock periods in picoseconds
    localparam int NS_RCD   = 15;
    localparam int NS_RP    = 15;
    localparam int NS_RC    = 55;
    localparam int PS_SLOW  = 5000;
    localparam int PS_FAST  = 3750;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    localparam int CYC_MAX = ceil_div(NS_RC * 1000, PS_FAST);
    localparam int TW      = $clog2(CYC_MAX + 1);

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_RDWR = 2'd2,
        CMD_PRE  = 2'd3
    } cmd_t;

    typedef struct packed {
        logic [TW-1:0] rcd;
        logic [TW-1:0] rp;
        logic [TW-1:0] rc;
    } tmg_t;

    typedef struct packed {
        logic          open;
        logic [TW-1:0] rcd_left;
        logic [TW-1:0] rp_left;
        logic [TW-1:0] rc_left;
    } bank_st_t;

    function automatic tmg_t grade_timing(input logic fast);
        tmg_t t;
        int   ps;
        ps    = fast ? PS_FAST : PS_SLOW;
        t.rcd = TW'(ceil_div(NS_RCD * 1000, ps));
        t.rp  = TW'(ceil_div(NS_RP * 1000, ps));
        t.rc  = TW'(ceil_div(NS_RC * 1000, ps));
        return t;
    endfunction

    function automatic logic [TW-1:0] tick_down(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - TW'(1);
    endfunction

endpackage

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddr_guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  cmd_t kind,
    input  tmg_t tmg,
    output logic act_ok,
    output logic col_ok,
    output logic pre_ok,
    output logic illegal
);

    bank_st_t st, nxt;

    assign act_ok = !st.open && (st.rp_left == '0) && (st.rc_left == '0);
    assign col_ok = st.open && (st.rcd_left == '0);
    assign pre_ok = st.open;

    always_comb begin
        illegal = 1'b0;
        if (hit) begin
            case (kind)
                CMD_ACT:  illegal = !act_ok;
                CMD_RDWR: illegal = !col_ok;
                CMD_PRE:  illegal = !pre_ok;
                default:  illegal = 1'b0;
            endcase
        end
    end

    always_comb begin
        nxt          = st;
        nxt.rcd_left = tick_down(st.rcd_left);
        nxt.rp_left  = tick_down(st.rp_left);
        nxt.rc_left  = tick_down(st.rc_left);
        if (hit && !illegal) begin
            case (kind)
                CMD_ACT: begin
                    nxt.open     = 1'b1;
                    nxt.rcd_left = tmg.rcd;
                    nxt.rc_left  = tmg.rc;
                end
                CMD_PRE: begin
                    nxt.open    = 1'b0;
                    nxt.rp_left = tmg.rp;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    // R4: an accepted activate opens the row but blocks column access
    a_r4_act_blocks_col: assert property (@(posedge clk) disable iff (rst)
        (hit && kind == CMD_ACT && act_ok) |=> (!col_ok && pre_ok && !act_ok));

    // R6: an accepted precharge closes the bank
    a_r6_pre_closes: assert property (@(posedge clk) disable iff (rst)
        (hit && kind == CMD_PRE && pre_ok) |=> (!act_ok && !pre_ok && !col_ok));

    // R7: a rejected command leaves the open/closed state alone
    a_r7_illegal_keeps_state: assert property (@(posedge clk) disable iff (rst)
        illegal |=> (pre_ok == $past(pre_ok)));

endmodule

// File: rtl/ddr_refresh_timer.sv
module ddr_refresh_timer #(
    parameter int N_SLOW = 1560,
    parameter int N_FAST = 2080,
    parameter int W      = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic fast,
    input  logic hot,
    input  logic ack,
    output logic req
);

    logic [W-1:0] cnt;
    logic [W-1:0] base;
    logic [W-1:0] limit;
    logic         wrap;

    always_comb begin
        base  = fast ? W'(N_FAST) : W'(N_SLOW);
        limit = hot ? (base >> 1) : base;
        wrap  = (cnt >= limit - W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            req <= 1'b0;
        end else begin
            cnt <= wrap ? '0 : cnt + W'(1);
            if (wrap)     req <= 1'b1;
            else if (ack) req <= 1'b0;
        end
    end

    // R9: request holds until acknowledged
    a_r9_req_sticky: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> req);

    // R9: acknowledge clears when no new interval ends
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !wrap) |=> !req);

    // R8: request only rises at an interval end
    a_r8_rise_on_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(wrap));

endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
    import ddr_guard_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int REF_NS    = 7800,
    localparam int BW       = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_kind,
    input  logic [BW-1:0]        cmd_bank,
    input  logic                 grade_fast,
    input  logic                 hot_mode,
    input  logic                 ref_ack,
    output logic [NUM_BANKS-1:0] act_ok,
    output logic [NUM_BANKS-1:0] col_ok,
    output logic [NUM_BANKS-1:0] pre_ok,
    output logic                 viol,
    output logic                 ref_req
);

    localparam int REF_SLOW = ceil_div(REF_NS * 1000, PS_SLOW);
    localparam int REF_FAST = ceil_div(REF_NS * 1000, PS_FAST);
    localparam int REF_W    = $clog2(REF_FAST + 1);

    cmd_t                 kind;
    tmg_t                 tmg;
    logic [NUM_BANKS-1:0] illegal;

    assign kind = cmd_t'(cmd_kind);
    assign tmg  = grade_timing(grade_fast);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = cmd_valid && (cmd_bank == BW'(b));
        ddr_bank_tracker u_bank (
            .clk     (clk),
            .rst     (rst),
            .hit     (hit),
            .kind    (kind),
            .tmg     (tmg),
            .act_ok  (act_ok[b]),
            .col_ok  (col_ok[b]),
            .pre_ok  (pre_ok[b]),
            .illegal (illegal[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) viol <= 1'b0;
        else     viol <= |illegal;
    end

    ddr_refresh_timer #(
        .N_SLOW (REF_SLOW),
        .N_FAST (REF_FAST),
        .W      (REF_W)
    ) u_refresh (
        .clk  (clk),
        .rst  (rst),
        .fast (grade_fast),
        .hot  (hot_mode),
        .ack  (ref_ack),
        .req  (ref_req)
    );

    // R2: at most one bank reacts to a command
    a_r2_one_bank: assert property (@(posedge clk) disable iff (rst)
        $onehot0(illegal));

    // R7: the flag only follows an issued command
    a_r7_viol_follows_cmd: assert property (@(posedge clk) disable iff (rst)
        viol |-> $past(cmd_valid));

endmodule

// File: tb/ddr_bank_guard_test.sv
`timescale 1ns/1ps
module ddr_bank_guard_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_kind = 2'd0;
    logic [2:0] cmd_bank = 3'd0;
    logic       grade_fast = 1'b0;
    logic       hot_mode = 1'b0;
    logic       ref_ack = 1'b0;
    logic [7:0] act_ok, col_ok, pre_ok;
    logic       viol, ref_req;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ddr_bank_guard #(.NUM_BANKS(8), .REF_NS(160)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .grade_fast(grade_fast), .hot_mode(hot_mode),
        .ref_ack(ref_ack), .act_ok(act_ok), .col_ok(col_ok), .pre_ok(pre_ok),
        .viol(viol), .ref_req(ref_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic fast, input logic hot);
        rst = 1'b1; grade_fast = fast; hot_mode = hot; ref_ack = 1'b0;
        step(2);
        rst = 1'b0;
    endtask

    task automatic issue(input logic [1:0] k, input logic [2:0] b);
        cmd_valid = 1'b1; cmd_kind = k; cmd_bank = b;
        step(1);
        cmd_valid = 1'b0; cmd_kind = 2'd0;
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0);
        chk("R1 act_ok", act_ok, 8'hFF);
        chk("R1 col_ok", col_ok, 8'h00);
        chk("R1 pre_ok", pre_ok, 8'h00);
        chk("R1 viol", viol, 0);
        chk("R1 ref_req", ref_req, 0);
        step(1);
        chk("R1 act_ok after first edge", act_ok, 8'hFF);
    endtask

    task automatic t_nop();
        do_reset(1'b0, 1'b0);
        issue(2'd0, 3'd4);
        chk("R2 nop viol", viol, 0);
        chk("R2 nop act_ok", act_ok, 8'hFF);
        chk("R2 nop pre_ok", pre_ok, 8'h00);
    endtask

    task automatic t_rcd(input logic fast, input int rcd);
        do_reset(fast, 1'b0);
        issue(2'd1, 3'd2);
        chk("R2 only bank 2 opens", pre_ok, 8'h04);
        chk("R5 act_ok closed after act", act_ok, 8'hFB);
        for (int k = 0; k <= rcd; k++) begin
            chk($sformatf("R4 R3 col_ok k=%0d", k), col_ok[2], (k >= rcd));
            step(1);
        end
    endtask

    task automatic t_rc(input logic fast, input int rc);
        do_reset(fast, 1'b0);
        issue(2'd1, 3'd5);
        issue(2'd3, 3'd5);
        chk("R6 pre closes", pre_ok[5], 0);
        chk("R6 col_ok after pre", col_ok[5], 0);
        for (int k = 1; k <= rc; k++) begin
            if (k >= rc - 1) chk($sformatf("R5 R3 tRC k=%0d", k), act_ok[5], (k >= rc));
            step(1);
        end
    endtask

    task automatic t_rp(input logic fast, input int rc, input int rp);
        do_reset(fast, 1'b0);
        issue(2'd1, 3'd1);
        step(rc);
        issue(2'd3, 3'd1);
        for (int m = 0; m <= rp; m++) begin
            chk($sformatf("R5 R3 tRP m=%0d", m), act_ok[1], (m >= rp));
            step(1);
        end
    endtask

    task automatic t_viol();
        do_reset(1'b0, 1'b0);
        issue(2'd2, 3'd0);
        chk("R7 rdwr idle viol", viol, 1);
        chk("R7 rdwr idle state", {act_ok[0], col_ok[0], pre_ok[0]}, 3'b100);
        step(1);
        chk("R7 viol one cycle", viol, 0);
        issue(2'd3, 3'd0);
        chk("R7 pre idle viol", viol, 1);
        chk("R7 pre idle state", act_ok[0], 1);
        issue(2'd1, 3'd0);
        chk("R7 legal act no viol", viol, 0);
        issue(2'd2, 3'd0);
        chk("R7 rdwr early viol", viol, 1);
        step(2);
        chk("R7 R4 col_ok unchanged by early rdwr", col_ok[0], 1);
        issue(2'd1, 3'd0);
        chk("R7 act open viol", viol, 1);
        chk("R7 act open keeps col_ok", col_ok[0], 1);
        issue(2'd2, 3'd0);
        chk("R7 legal rdwr", viol, 0);
    endtask

    task automatic t_refresh(input logic fast, input logic hot, input int n);
        do_reset(fast, hot);
        step(n - 1);
        chk($sformatf("R8 before interval n=%0d", n), ref_req, 0);
        step(1);
        chk($sformatf("R8 at interval n=%0d", n), ref_req, 1);
    endtask

    task automatic t_sticky();
        t_refresh(1'b0, 1'b0, 32);
        step(5);
        chk("R9 sticky", ref_req, 1);
        ref_ack = 1'b1;
        step(1);
        ref_ack = 1'b0;
        chk("R9 ack clears", ref_req, 0);
        step(25);
        chk("R8 restart before", ref_req, 0);
        step(1);
        chk("R8 restart at", ref_req, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(1);
        t_reset();
        t_nop();
        t_rcd(1'b0, 3);
        t_rcd(1'b1, 4);
        t_rc(1'b0, 11);
        t_rc(1'b1, 15);
        t_rp(1'b0, 11, 3);
        t_rp(1'b1, 15, 4);
        t_viol();
        t_sticky();
        t_refresh(1'b0, 1'b1, 16);
        t_refresh(1'b1, 1'b0, 43);
        t_refresh(1'b1, 1'b1, 21);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule